// File: doc/BRIEF.md
# Programmed I/O Device Responder

This block is the device-side end of a direct programmed-transfer channel. The channel puts a command and a device number on a 16-bit address bus and raises a select line. On a write it also drives a 16-bit data bus with one odd-parity bit per byte. The block compares the device field with its own number. When they match it decodes the command and checks the write parity. From that it decides whether to accept the transfer and which 3-bit condition code to report. After the channel raises the address gate, the block drives the condition code, and on reads the read data, for one clock. It then raises the gate return. It holds both values until the gate and the data strobe have both fallen.

Internal state changes only at the moment the protocol permits. A write commits on the clock that sees the data strobe. The device-reset command is the one exception: it clears the device on the clock that sees the address gate. The device state is a 16-bit data register and an interrupt request with an enable, a pending flag and a 2-bit level. If the channel drops the gate without strobing, the transfer is aborted and nothing commits.

The device field is address bits 7:0. The command is bits 15:8, and command bit 15 set means a read. Commands: 8'h10 write data register; 8'h20 prepare (wdata bit 2 = interrupt enable, bits 1:0 = level); 8'h30 acknowledge interrupt (clears pending); 8'h3F device reset; 8'h90 read data register; 8'hA0 read status. Any other value is rejected.

FSM states: IDLE, SELECT, DRIVE, RETURN, STROBE, HOLD. Transitions:
- IDLE→SELECT: selected.
- SELECT→IDLE: selection lost.
- SELECT→DRIVE: gate seen; latch the result, and a device reset acts here.
- DRIVE→RETURN: gate still high.
- DRIVE→IDLE: gate and strobe both low.
- DRIVE→HOLD: gate low, strobe high.
- RETURN→STROBE: strobe with gate high; commit.
- RETURN→HOLD: strobe with gate low; commit.
- RETURN→IDLE: gate fell without a strobe (abort).
- STROBE→HOLD: gate low.
- STROBE→IDLE: both low.
- HOLD→IDLE: strobe low.

Top module: `pio_responder`

## Requirements
- R1: The block responds only when sel_i is high and addr_bus_i[7:0] equals DEV_ADDR. Otherwise cc_en_o and gate_ret_o stay low.
- R2: Selection without an address gate changes no device state.
- R3: cc_en_o (and rdata_en_o on reads) rises on the clock that recognises the address gate. gate_ret_o rises exactly one clock later.
- R4: cc_o and rdata_o stay constant while cc_en_o is high. cc_en_o stays high until the gate and the strobe are both low, and falls the clock after. gate_ret_o falls the clock after the gate is seen low.
- R5: Condition codes are 3'b111 for accepted, 3'b010 for an unknown command and 3'b011 for a write parity error. Command bit 15 selects a read.
- R6: Write data needs odd parity per byte: wpar_i[b] makes byte b's ones count odd. A write that fails the check reports 3'b011 and commits nothing.
- R7: Writes commit only on the clock that recognises the data strobe. An aborted transfer commits nothing.
- R8: Device reset clears the data register, the enable, the level and the pending flag on the gate-recognition clock. The request is therefore low before the strobe.
- R9: Prepare loads the enable and the level on strobe recognition, while the strobe is still high. Disabling drops a pending request.
- R10: irq_event_i sets pending. irq_req_o = pending AND enable. Acknowledge clears pending.
- R11: Read data returns the data register. Read status returns {pending, enable, level} in bits 3:0 and zeros above.
- R12: After reset all outputs are low and all device state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Select line from channel |
| addr_bus_i | input | 16 | Command (15:8) and device field (7:0) |
| addr_gate_i | input | 1 | Address gate |
| data_strobe_i | input | 1 | Data strobe |
| wdata_i | input | 16 | Write data |
| wpar_i | input | 2 | Odd parity per write byte |
| irq_event_i | input | 1 | Device event that sets interrupt pending |
| rdata_o | output | 16 | Read data |
| rdata_en_o | output | 1 | Read data driven |
| cc_o | output | 3 | Condition code |
| cc_en_o | output | 1 | Condition code driven |
| gate_ret_o | output | 1 | Address gate return |
| irq_req_o | output | 1 | Interrupt request |
| irq_level_o | output | 2 | Requested interrupt level |

## Verification
Inputs change on falling edges. Counting from the rising edge that first sees the gate, cc_en_o is checked at the next falling edge and gate_ret_o one falling edge later. State committed by the strobe is due at the falling edge after the strobe is seen, while the strobe is still high. A device reset is already visible when the gate return is sampled. The drop of cc_en_o is checked one edge after the strobe is released, and the drop of gate_ret_o one edge after the gate is released. Every value is sampled at those fixed falling edges rather than by waiting for the signal to change.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [2:0] {
        K_NONE, K_WDATA, K_PREP, K_ACK, K_RESET, K_RDATA, K_RSTAT
    } cmd_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SELECT, S_DRIVE, S_RETURN, S_STROBE, S_HOLD
    } rsp_state_e;

    localparam int CC_W = 3;
    localparam logic [CC_W-1:0] CC_ACCEPT = 3'b111;
    localparam logic [CC_W-1:0] CC_BADCMD = 3'b010;
    localparam logic [CC_W-1:0] CC_PARITY = 3'b011;

    localparam logic [7:0] OP_WDATA = 8'h10;
    localparam logic [7:0] OP_PREP  = 8'h20;
    localparam logic [7:0] OP_ACK   = 8'h30;
    localparam logic [7:0] OP_RESET = 8'h3F;
    localparam logic [7:0] OP_RDATA = 8'h90;
    localparam logic [7:0] OP_RSTAT = 8'hA0;

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter int          CMD_W    = 8,
    parameter int          DEVF_W   = 8,
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  DEV_ADDR = 8'h2C,
    localparam int         ADDR_W   = CMD_W + DEVF_W,
    localparam int         NBYTES   = DATA_W / 8
) (
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NBYTES-1:0] wpar_i,
    output logic              hit_o,
    output logic              is_read_o,
    output cmd_kind_e         kind_o,
    output logic              accept_o,
    output logic [CC_W-1:0]   cc_o
);

    logic [CMD_W-1:0]  cmd;
    logic [NBYTES-1:0] lane_ok;
    logic              par_ok;

    assign cmd   = addr_i[ADDR_W-1 -: CMD_W];
    assign hit_o = sel_i && (addr_i[DEVF_W-1:0] == DEVF_W'(DEV_ADDR));
    assign is_read_o = cmd[CMD_W-1];

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane_ok[b] = ^{wpar_i[b], wdata_i[8*b +: 8]};
    end
    assign par_ok = &lane_ok;

    always_comb begin
        unique case (cmd)
            CMD_W'(OP_WDATA): kind_o = K_WDATA;
            CMD_W'(OP_PREP):  kind_o = K_PREP;
            CMD_W'(OP_ACK):   kind_o = K_ACK;
            CMD_W'(OP_RESET): kind_o = K_RESET;
            CMD_W'(OP_RDATA): kind_o = K_RDATA;
            CMD_W'(OP_RSTAT): kind_o = K_RSTAT;
            default:          kind_o = K_NONE;
        endcase
    end

    always_comb begin
        if (kind_o == K_NONE) begin
            cc_o     = CC_BADCMD;
            accept_o = 1'b0;
        end else if (!is_read_o && !par_ok) begin
            cc_o     = CC_PARITY;
            accept_o = 1'b0;
        end else begin
            cc_o     = CC_ACCEPT;
            accept_o = 1'b1;
        end
    end

endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LVL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  cmd_kind_e         kind_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              reset_now_i,
    input  logic              irq_event_i,
    output logic [DATA_W-1:0] data_q_o,
    output logic              irq_en_o,
    output logic              irq_pend_o,
    output logic [LVL_W-1:0]  irq_lvl_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q_o   <= '0;
            irq_en_o   <= 1'b0;
            irq_pend_o <= 1'b0;
            irq_lvl_o  <= '0;
        end else if (reset_now_i) begin
            data_q_o   <= '0;
            irq_en_o   <= 1'b0;
            irq_pend_o <= 1'b0;
            irq_lvl_o  <= '0;
        end else begin
            if (irq_event_i) begin
                irq_pend_o <= 1'b1;
            end
            if (commit_i) begin
                unique case (kind_i)
                    K_WDATA: data_q_o <= wdata_i;
                    K_PREP: begin
                        irq_en_o  <= wdata_i[LVL_W];
                        irq_lvl_o <= wdata_i[LVL_W-1:0];
                    end
                    K_ACK:   irq_pend_o <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pio_fsm.sv
module pio_fsm
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic       gate_i,
    input  logic       strobe_i,
    input  logic       accept_live_i,
    input  cmd_kind_e  kind_live_i,
    input  logic       accept_q_i,
    output rsp_state_e state_o,
    output logic       latch_o,
    output logic       commit_o,
    output logic       reset_now_o,
    output logic       cc_en_o,
    output logic       gate_ret_o
);

    rsp_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_o <= S_IDLE;
        else        state_o <= nxt;
    end

    always_comb begin
        nxt = state_o;
        unique case (state_o)
            S_IDLE:   if (hit_i) nxt = S_SELECT;
            S_SELECT: begin
                if (!hit_i)      nxt = S_IDLE;
                else if (gate_i) nxt = S_DRIVE;
            end
            S_DRIVE: begin
                if (gate_i)        nxt = S_RETURN;
                else if (strobe_i) nxt = S_HOLD;
                else               nxt = S_IDLE;
            end
            S_RETURN: begin
                if (strobe_i)    nxt = gate_i ? S_STROBE : S_HOLD;
                else if (!gate_i) nxt = S_IDLE;
            end
            S_STROBE: begin
                if (!gate_i) nxt = strobe_i ? S_HOLD : S_IDLE;
            end
            S_HOLD:   if (!strobe_i) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_comb begin
        latch_o     = 1'b0;
        commit_o    = 1'b0;
        reset_now_o = 1'b0;
        cc_en_o     = 1'b0;
        gate_ret_o  = 1'b0;
        unique case (state_o)
            S_IDLE: ;
            S_SELECT: begin
                latch_o     = hit_i && gate_i;
                reset_now_o = hit_i && gate_i && accept_live_i
                              && (kind_live_i == K_RESET);
            end
            S_DRIVE:  cc_en_o = 1'b1;
            S_RETURN: begin
                cc_en_o    = 1'b1;
                gate_ret_o = 1'b1;
                commit_o   = strobe_i && accept_q_i;
            end
            S_STROBE: begin
                cc_en_o    = 1'b1;
                gate_ret_o = 1'b1;
            end
            S_HOLD:   cc_en_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/pio_responder.sv
module pio_responder
    import pio_pkg::*;
#(
    parameter int         CMD_W    = 8,
    parameter int         DEVF_W   = 8,
    parameter int         DATA_W   = 16,
    parameter int         LVL_W    = 2,
    parameter logic [7:0] DEV_ADDR = 8'h2C,
    localparam int        ADDR_W   = CMD_W + DEVF_W,
    localparam int        NBYTES   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_bus_i,
    input  logic              addr_gate_i,
    input  logic              data_strobe_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NBYTES-1:0] wpar_i,
    input  logic              irq_event_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_en_o,
    output logic [CC_W-1:0]   cc_o,
    output logic              cc_en_o,
    output logic              gate_ret_o,
    output logic              irq_req_o,
    output logic [LVL_W-1:0]  irq_level_o
);

    logic              hit, is_read, accept;
    cmd_kind_e         kind;
    logic [CC_W-1:0]   cc_live;
    rsp_state_e        state;
    logic              latch, commit, reset_now, cc_en;
    logic [DATA_W-1:0] data_q;
    logic              irq_en, irq_pend;
    logic [LVL_W-1:0]  irq_lvl;

    logic [CC_W-1:0]   cc_q;
    logic [DATA_W-1:0] rdata_q, wdata_q;
    logic              is_read_q, accept_q;
    cmd_kind_e         kind_q;
    logic [DATA_W-1:0] rd_mux;

    pio_decode #(
        .CMD_W(CMD_W), .DEVF_W(DEVF_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)
    ) u_dec (
        .sel_i(sel_i), .addr_i(addr_bus_i), .wdata_i(wdata_i), .wpar_i(wpar_i),
        .hit_o(hit), .is_read_o(is_read), .kind_o(kind),
        .accept_o(accept), .cc_o(cc_live)
    );

    pio_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .gate_i(addr_gate_i),
        .strobe_i(data_strobe_i), .accept_live_i(accept), .kind_live_i(kind),
        .accept_q_i(accept_q), .state_o(state), .latch_o(latch),
        .commit_o(commit), .reset_now_o(reset_now), .cc_en_o(cc_en),
        .gate_ret_o(gate_ret_o)
    );

    pio_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .kind_i(kind_q),
        .wdata_i(wdata_q), .reset_now_i(reset_now), .irq_event_i(irq_event_i),
        .data_q_o(data_q), .irq_en_o(irq_en), .irq_pend_o(irq_pend),
        .irq_lvl_o(irq_lvl)
    );

    always_comb begin
        unique case (kind)
            K_RDATA: rd_mux = data_q;
            K_RSTAT: rd_mux = DATA_W'({irq_pend, irq_en, irq_lvl});
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q      <= '0;
            rdata_q   <= '0;
            wdata_q   <= '0;
            is_read_q <= 1'b0;
            accept_q  <= 1'b0;
            kind_q    <= K_NONE;
        end else if (latch) begin
            cc_q      <= cc_live;
            rdata_q   <= rd_mux;
            wdata_q   <= wdata_i;
            is_read_q <= is_read;
            accept_q  <= accept;
            kind_q    <= kind;
        end
    end

    assign cc_en_o     = cc_en;
    assign cc_o        = cc_en ? cc_q : '0;
    assign rdata_en_o  = cc_en && is_read_q;
    assign rdata_o     = rdata_en_o ? rdata_q : '0;
    assign irq_req_o   = irq_pend && irq_en;
    assign irq_level_o = irq_lvl;

endmodule

// File: rtl/pio_responder_chk.sv
module pio_responder_chk #(
    parameter int         DEVF_W   = 8,
    parameter int         ADDR_W   = 16,
    parameter int         DATA_W   = 16,
    parameter int         LVL_W    = 2,
    parameter logic [7:0] DEV_ADDR = 8'h2C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic [ADDR_W-1:0] addr_bus_i,
    input logic              addr_gate_i,
    input logic              data_strobe_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rdata_en_o,
    input logic [2:0]        cc_o,
    input logic              cc_en_o,
    input logic              gate_ret_o,
    input logic [LVL_W-1:0]  irq_level_o,
    input logic [DATA_W-1:0] data_reg_i
);

    p_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_en_o) |-> $past(sel_i && addr_gate_i
                                 && addr_bus_i[DEVF_W-1:0] == DEVF_W'(DEV_ADDR)));

    p_cc_before_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ret_o) |-> $past(cc_en_o));

    p_rdata_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_en_o |-> cc_en_o);

    p_cc_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_en_o && $past(cc_en_o)) |-> ($stable(cc_o) && $stable(rdata_o)));

    p_cc_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_en_o && (addr_gate_i || data_strobe_i)) |=> cc_en_o);

    p_ret_needs_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_gate_i |=> !gate_ret_o);

    p_commit_moment_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_reg_i) |-> ($past(data_strobe_i) || $past(addr_gate_i)));

    p_level_moment_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_level_o) |-> ($past(data_strobe_i) || $past(addr_gate_i)));

endmodule

bind pio_responder pio_responder_chk #(
    .DEVF_W(DEVF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
    .DEV_ADDR(DEV_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_bus_i(addr_bus_i),
    .addr_gate_i(addr_gate_i), .data_strobe_i(data_strobe_i),
    .rdata_o(rdata_o), .rdata_en_o(rdata_en_o), .cc_o(cc_o),
    .cc_en_o(cc_en_o), .gate_ret_o(gate_ret_o), .irq_level_o(irq_level_o),
    .data_reg_i(data_q)
);

// File: tb/pio_responder_tb.sv
module pio_responder_tb_top;

    localparam logic [7:0] DEV = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, gate = 1'b0, strobe = 1'b0, ev = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [1:0]  wpar = '0;
    logic [15:0] rdata;
    logic        rdata_en, cc_en, gret, irq_req;
    logic [2:0]  cc;
    logic [1:0]  irq_lvl;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [2:0]  got_cc;
    logic [15:0] got_rd;
    logic        pre_req, mid_req;
    logic [1:0]  pre_lvl, mid_lvl;

    always #5 clk = ~clk;

    pio_responder #(.DEV_ADDR(DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .addr_bus_i(addr),
        .addr_gate_i(gate), .data_strobe_i(strobe), .wdata_i(wdata),
        .wpar_i(wpar), .irq_event_i(ev), .rdata_o(rdata),
        .rdata_en_o(rdata_en), .cc_o(cc), .cc_en_o(cc_en),
        .gate_ret_o(gret), .irq_req_o(irq_req), .irq_level_o(irq_lvl)
    );

    // {cmd, data, bad parity, expected cc, expected read data}
    localparam int NV = 8;
    localparam logic [43:0] VEC [NV] = '{
        {8'h10, 16'h1234, 1'b0, 3'b111, 16'h0000},
        {8'h90, 16'h0000, 1'b0, 3'b111, 16'h1234},
        {8'h10, 16'hABCD, 1'b1, 3'b011, 16'h0000},
        {8'h90, 16'h0000, 1'b0, 3'b111, 16'h1234},
        {8'h55, 16'h0000, 1'b0, 3'b010, 16'h0000},
        {8'hC5, 16'h0000, 1'b0, 3'b010, 16'h0000},
        {8'h20, 16'h0006, 1'b0, 3'b111, 16'h0000},
        {8'hA0, 16'h0000, 1'b0, 3'b111, 16'h0006}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] par_for(input logic [15:0] d, input bit bad);
        logic [1:0] p;
        p[0] = ~^d[7:0];
        p[1] = ~^d[15:8];
        if (bad) p[0] = ~p[0];
        return p;
    endfunction

    // abort=1: gate falls without strobe
    task automatic txn(input logic [7:0] cmd, input logic [15:0] d, input bit bad,
                       input bit abort);
        @(negedge clk);
        addr = {cmd, DEV}; sel = 1'b1; wdata = d; wpar = par_for(d, bad);
        @(negedge clk);
        gate = 1'b1;
        @(negedge clk);
        chk(cc_en === 1'b1, "R3 cc_en at gate", 32'(cc_en), 1);
        chk(gret === 1'b0, "R3 ret one clock later", 32'(gret), 0);
        chk(rdata_en === cmd[7], "R3 rdata_en on reads", 32'(rdata_en), 32'(cmd[7]));
        @(negedge clk);
        chk(gret === 1'b1, "R3 ret raised", 32'(gret), 1);
        got_cc = cc; got_rd = rdata; pre_req = irq_req; pre_lvl = irq_lvl;
        if (abort) begin
            gate = 1'b0;
            @(negedge clk);
            chk(gret === 1'b0 && cc_en === 1'b0, "R7 abort ends", 32'({gret, cc_en}), 0);
            sel = 1'b0;
            return;
        end
        strobe = 1'b1;
        @(negedge clk);
        mid_req = irq_req; mid_lvl = irq_lvl;
        chk(cc === got_cc && rdata === got_rd, "R4 stable under strobe",
            32'({cc, rdata}), 32'({got_cc, got_rd}));
        @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
        chk(gret === 1'b0 && cc_en === 1'b1, "R4 ret drops, cc held",
            32'({gret, cc_en}), 32'(2'b01));
        chk(cc === got_cc, "R4 cc held in hold", 32'(cc), 32'(got_cc));
        strobe = 1'b0;
        @(negedge clk);
        chk(cc_en === 1'b0, "R4 cc_en drops", 32'(cc_en), 0);
        sel = 1'b0;
    endtask

    task automatic pulse_event();
        @(negedge clk); ev = 1'b1;
        @(negedge clk); ev = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cc_en === 0 && gret === 0 && rdata_en === 0, "R12 outputs idle",
            32'({cc_en, gret, rdata_en}), 0);
        chk(irq_req === 0 && irq_lvl === 0, "R12 irq clear", 32'({irq_req, irq_lvl}), 0);
        txn(8'hA0, 16'h0, 1'b0, 1'b0);
        chk(got_rd === 16'h0, "R12 status zero", 32'(got_rd), 0);

        // table walk: R5 codes, R6 parity, R11 reads
        for (int i = 0; i < NV; i++) begin
            txn(VEC[i][43:36], VEC[i][35:20], VEC[i][19], 1'b0);
            chk(got_cc === VEC[i][18:16], $sformatf("R5/R6 cc vec %0d", i),
                32'(got_cc), 32'(VEC[i][18:16]));
            if (VEC[i][43])
                chk(got_rd === VEC[i][15:0], $sformatf("R11 rdata vec %0d", i),
                    32'(got_rd), 32'(VEC[i][15:0]));
        end

        // R1: other device number and missing select
        @(negedge clk);
        addr = {8'h90, DEV ^ 8'h01}; sel = 1'b1; gate = 1'b1;
        repeat (4) @(negedge clk);
        chk(cc_en === 0 && gret === 0, "R1 wrong device ignored", 32'({cc_en, gret}), 0);
        addr = {8'h90, DEV}; sel = 1'b0;
        repeat (4) @(negedge clk);
        chk(cc_en === 0 && gret === 0, "R1 no select ignored", 32'({cc_en, gret}), 0);
        gate = 1'b0;

        // R2: select+match with strobe toggling but no gate
        @(negedge clk);
        addr = {8'h10, DEV}; wdata = 16'hFFFF; wpar = par_for(16'hFFFF, 0); sel = 1'b1;
        repeat (3) @(negedge clk);
        strobe = 1'b1; @(negedge clk); strobe = 1'b0;
        @(negedge clk); sel = 1'b0;
        txn(8'h90, 16'h0, 1'b0, 1'b0);
        chk(got_rd === 16'h1234, "R2 selection alone no change", 32'(got_rd), 32'h1234);

        // R7: aborted write commits nothing
        txn(8'h10, 16'h5555, 1'b0, 1'b1);
        txn(8'h90, 16'h0, 1'b0, 1'b0);
        chk(got_rd === 16'h1234, "R7 abort no commit", 32'(got_rd), 32'h1234);

        // R10: event with enable set from table (en=1,lvl=2)
        pulse_event();
        chk(irq_req === 1 && irq_lvl === 2, "R10 request raised",
            32'({irq_req, irq_lvl}), 32'(3'b110));

        // R9: prepare changes level while pending, at strobe
        txn(8'h20, 16'h0005, 1'b0, 1'b0);
        chk(pre_lvl === 2, "R7 level unchanged before strobe", 32'(pre_lvl), 2);
        chk(mid_lvl === 1 && mid_req === 1, "R9 level changed before strobe falls",
            32'({mid_req, mid_lvl}), 32'(3'b101));

        // R10: acknowledge clears pending
        txn(8'h30, 16'h0000, 1'b0, 1'b0);
        chk(pre_req === 1 && mid_req === 0, "R10 ack clears",
            32'({pre_req, mid_req}), 32'(2'b10));

        // R9: disable drops request, re-enable restores it
        pulse_event();
        chk(irq_req === 1, "R10 request again", 32'(irq_req), 1);
        txn(8'h20, 16'h0000, 1'b0, 1'b0);
        chk(mid_req === 0, "R9 disable drops request", 32'(mid_req), 0);
        txn(8'h20, 16'h0007, 1'b0, 1'b0);
        chk(mid_req === 1 && mid_lvl === 3, "R9 re-enable", 32'({mid_req, mid_lvl}), 32'(3'b111));
        txn(8'hA0, 16'h0, 1'b0, 1'b0);
        chk(got_rd === 16'h000F, "R11 status pend/en/lvl", 32'(got_rd), 32'h000F);

        // R8: device reset acts at gate
        txn(8'h3F, 16'h0000, 1'b0, 1'b0);
        chk(got_cc === 3'b111, "R8 reset accepted", 32'(got_cc), 7);
        chk(pre_req === 0 && pre_lvl === 0, "R8 request dropped before strobe",
            32'({pre_req, pre_lvl}), 0);
        txn(8'h90, 16'h0, 1'b0, 1'b0);
        chk(got_rd === 16'h0, "R8 data cleared", 32'(got_rd), 0);
        txn(8'hA0, 16'h0, 1'b0, 1'b0);
        chk(got_rd === 16'h0, "R8 status cleared", 32'(got_rd), 0);
        pulse_event();
        chk(irq_req === 0, "R10 disabled request masked", 32'(irq_req), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule